// File: doc/BRIEF.md
# Driver Impedance Update Scheduler

This block sits between an external impedance calibration source and the output drivers. It decides on which clock edge a newly requested driver impedance code may take effect. The calibration source presents a requested code at any time. The host logic flags every cycle in which the outputs will be driven. The block holds the applied code steady while the outputs are busy, and while the minimum spacing since the last change has not yet elapsed. When the code changes, a one-cycle strobe is raised, aligned with the new value.

A spacing timer runs on every clock, whatever kind of cycle the outputs see. A long run of output activity therefore cannot delay an update beyond the first idle edge once the spacing has elapsed. A separate qualification counter tallies idle cycles since reset, and it raises a calibrated flag once enough of them have passed.

Top module: `drv_imp_sched`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the applied code equals the mid-scale value (only the most significant code bit set; 32 for a 6-bit code), the strobe is low and the calibrated flag is low.
- R2: The first edge after reset is already eligible: an idle edge that presents a code different from the applied code updates it on that edge.
- R3: On an edge where `out_active` is high, the applied code does not change and no strobe follows, whatever the requested code.
- R4: Two code changes happen on edges at least MIN_GAP clock edges apart. The spacing counts every edge, idle or active. With MIN_GAP=32, an edge 31 edges after an update cannot apply a change, and an edge exactly 32 edges after it can.
- R5: An eligible idle edge whose requested code equals the applied code produces no strobe. Eligibility stays open, so a later differing code on any idle edge is applied at once.
- R6: Once MIN_GAP edges have passed during continuous output activity, the first idle edge with a differing code applies the update.
- R7: `upd_strobe` is high for exactly the one cycle in which `cur_code` shows a new value, and at no other time.
- R8: `calibrated` stays low until QUAL_CYCLES idle edges (out_active low) have occurred since reset. These edges need not be consecutive. The flag goes high in the cycle after the QUAL_CYCLES-th idle edge.
- R9: Once high, `calibrated` stays high until the next reset, because the idle counter saturates instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| out_active | input | 1 | High when the outputs are driven in this cycle |
| req_code | input | CODE_W | Impedance code requested by the calibration source |
| cur_code | output | CODE_W | Impedance code currently applied to the drivers |
| upd_strobe | output | 1 | One-cycle pulse aligned with a new `cur_code` |
| calibrated | output | 1 | High once the idle-cycle qualification has been met |

## Verification
The bench builds the block with its default parameters: a 6-bit code, a 32-edge spacing and a 1024-cycle qualification. It can therefore probe the spacing boundary at edges 31 and 32 after an update. It can also run a full qualification, with active cycles mixed in, and then check that the flag holds well past the threshold. Long busy runs followed by a single idle edge show that activity does not stall the spacing timer.

// File: rtl/drv_imp_pkg.sv
package drv_imp_pkg;

    typedef enum logic [1:0] {
        DEC_BUSY  = 2'd0,
        DEC_WAIT  = 2'd1,
        DEC_SAME  = 2'd2,
        DEC_APPLY = 2'd3
    } upd_dec_e;

    function automatic int mid_scale(input int width);
        return 1 << (width - 1);
    endfunction

    function automatic upd_dec_e decide(input logic eligible,
                                        input logic active,
                                        input logic same);
        if (active)
            return DEC_BUSY;
        else if (!eligible)
            return DEC_WAIT;
        else if (same)
            return DEC_SAME;
        else
            return DEC_APPLY;
    endfunction

endpackage

// File: rtl/drv_imp_gap_timer.sv
module drv_imp_gap_timer #(
    parameter int MIN_GAP = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic eligible
);
    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);
    localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= GAP_MAX;
        else if (restart)
            cnt_q <= GAP_ONE;
        else if (cnt_q != GAP_MAX)
            cnt_q <= cnt_q + GAP_ONE;
    end

    assign eligible = (cnt_q == GAP_MAX);

endmodule

// File: rtl/drv_imp_qual_counter.sv
module drv_imp_qual_counter #(
    parameter int QUAL_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    output logic done
);
    localparam int QUAL_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [QUAL_W-1:0] QUAL_MAX = QUAL_W'(QUAL_CYCLES);
    localparam logic [QUAL_W-1:0] QUAL_ONE = QUAL_W'(1);

    logic [QUAL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (idle && (cnt_q != QUAL_MAX))
            cnt_q <= cnt_q + QUAL_ONE;
    end

    assign done = (cnt_q == QUAL_MAX);

endmodule

// File: rtl/drv_imp_apply.sv
module drv_imp_apply
    import drv_imp_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              out_active,
    input  logic              eligible,
    input  logic [CODE_W-1:0] req_code,
    output logic [CODE_W-1:0] cur_code,
    output logic              upd_strobe,
    output logic              apply_now
);
    localparam logic [CODE_W-1:0] CODE_DEF = CODE_W'(mid_scale(CODE_W));

    upd_dec_e dec;
    logic     same;

    assign same      = (req_code == cur_code);
    assign dec       = decide(eligible, out_active, same);
    assign apply_now = (dec == DEC_APPLY);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_code   <= CODE_DEF;
            upd_strobe <= 1'b0;
        end else begin
            upd_strobe <= apply_now;
            if (apply_now)
                cur_code <= req_code;
        end
    end

endmodule

// File: rtl/drv_imp_sched.sv
module drv_imp_sched #(
    parameter int CODE_W      = 6,
    parameter int MIN_GAP     = 32,
    parameter int QUAL_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              out_active,
    input  logic [CODE_W-1:0] req_code,
    output logic [CODE_W-1:0] cur_code,
    output logic              upd_strobe,
    output logic              calibrated
);
    logic eligible;
    logic apply_now;

    drv_imp_gap_timer #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .restart  (apply_now),
        .eligible (eligible)
    );

    drv_imp_apply #(.CODE_W(CODE_W)) u_apply (
        .clk        (clk),
        .rst        (rst),
        .out_active (out_active),
        .eligible   (eligible),
        .req_code   (req_code),
        .cur_code   (cur_code),
        .upd_strobe (upd_strobe),
        .apply_now  (apply_now)
    );

    drv_imp_qual_counter #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk  (clk),
        .rst  (rst),
        .idle (!out_active),
        .done (calibrated)
    );

endmodule

// File: rtl/drv_imp_sched_chk.sv
module drv_imp_sched_chk #(
    parameter int CODE_W      = 6,
    parameter int MIN_GAP     = 32,
    parameter int QUAL_CYCLES = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              out_active,
    input logic [CODE_W-1:0] cur_code,
    input logic              upd_strobe,
    input logic              calibrated
);
    localparam int GAP_W  = $clog2(MIN_GAP + 1);
    localparam int QUAL_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [GAP_W-1:0]  SPAN_MAX = GAP_W'(MIN_GAP);
    localparam logic [QUAL_W-1:0] SEEN_MAX = QUAL_W'(QUAL_CYCLES);

    logic [GAP_W-1:0]  since_q;
    logic [QUAL_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)
            since_q <= SPAN_MAX;
        else if (upd_strobe)
            since_q <= GAP_W'(1);
        else if (since_q != SPAN_MAX)
            since_q <= since_q + GAP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= '0;
        else if (!out_active && (seen_q != SEEN_MAX))
            seen_q <= seen_q + QUAL_W'(1);
    end

    // R3
    busy_no_update_chk: assert property (@(posedge clk) disable iff (rst)
        out_active |=> !upd_strobe);

    // R4
    min_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |-> (since_q == SPAN_MAX));

    // R7
    strobe_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_code) |-> upd_strobe);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |=> !upd_strobe);

    // R8
    qual_reached_chk: assert property (@(posedge clk) disable iff (rst)
        calibrated |-> (seen_q == SEEN_MAX));

    // R9
    cal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        calibrated |=> calibrated);

endmodule

bind drv_imp_sched drv_imp_sched_chk #(
    .CODE_W      (CODE_W),
    .MIN_GAP     (MIN_GAP),
    .QUAL_CYCLES (QUAL_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_active (out_active),
    .cur_code   (cur_code),
    .upd_strobe (upd_strobe),
    .calibrated (calibrated)
);

// File: tb/drv_imp_sched_tb.sv
module drv_imp_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 6;
    localparam int MIN_GAP    = 32;
    localparam int QUAL       = 1024;
    localparam int MID        = 32;

    // entry: {active, req_code[5:0], exp_strobe, exp_code[5:0]}
    localparam int NVEC = 4;
    localparam logic [13:0] VEC [0:NVEC-1] = '{
        {1'b0, 6'd10, 1'b1, 6'd10},   // R2 first edge eligible
        {1'b0, 6'd20, 1'b0, 6'd10},   // R4 too soon
        {1'b1, 6'd20, 1'b0, 6'd10},   // R3 busy
        {1'b0, 6'd10, 1'b0, 6'd10}    // R5 same code, no strobe
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              out_active = 1'b1;
    logic [CODE_W-1:0] req_code = '0;
    logic [CODE_W-1:0] cur_code;
    logic              upd_strobe;
    logic              calibrated;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    drv_imp_sched #(.CODE_W(CODE_W), .MIN_GAP(MIN_GAP), .QUAL_CYCLES(QUAL)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .out_active (out_active),
        .req_code   (req_code),
        .cur_code   (cur_code),
        .upd_strobe (upd_strobe),
        .calibrated (calibrated)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic act, input logic [CODE_W-1:0] code);
        @(negedge clk);
        out_active = act;
        req_code   = code;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        out_active = 1'b1;
        req_code = CODE_W'(MID);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 code", int'(cur_code), MID);
        chk("R1 strobe", int'(upd_strobe), 0);
        chk("R1 cal", int'(calibrated), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][13], VEC[i][12:7]);
            chk("R2/R3/R4/R5 vec strobe", int'(upd_strobe), int'(VEC[i][6]));
            chk("R2/R3/R4/R5 vec code", int'(cur_code), int'(VEC[i][5:0]));
        end

        // R4: edges 4..31 after the update are still too early
        for (int k = 4; k < MIN_GAP; k++) begin
            step(1'b0, 6'd20);
            chk("R4 early strobe", int'(upd_strobe), 0);
            chk("R4 early code", int'(cur_code), 10);
        end
        step(1'b0, 6'd20);
        chk("R4 boundary strobe", int'(upd_strobe), 1);
        chk("R4 boundary code", int'(cur_code), 20);
        step(1'b0, 6'd20);
        chk("R7 one-cycle strobe", int'(upd_strobe), 0);

        // R3 / R6: long busy run, then one idle edge
        for (int k = 0; k < 40; k++) begin
            step(1'b1, 6'd5);
            chk("R3 busy strobe", int'(upd_strobe), 0);
        end
        chk("R3 busy code", int'(cur_code), 20);
        step(1'b0, 6'd5);
        chk("R6 idle after busy strobe", int'(upd_strobe), 1);
        chk("R6 idle after busy code", int'(cur_code), 5);

        // R5: equal code keeps the window open
        for (int k = 0; k < 40; k++) begin
            step(1'b0, 6'd5);
            chk("R5 same strobe", int'(upd_strobe), 0);
        end
        step(1'b0, 6'd7);
        chk("R5 open window strobe", int'(upd_strobe), 1);
        chk("R5 open window code", int'(cur_code), 7);

        // R8 / R9: qualification count with active cycles mixed in
        do_reset();
        for (int i = 0; i < QUAL - 1; i++) begin
            if (i % 3 == 0) step(1'b1, CODE_W'(MID));
            step(1'b0, CODE_W'(MID));
        end
        chk("R8 before threshold", int'(calibrated), 0);
        step(1'b1, CODE_W'(MID));
        chk("R8 busy not counted", int'(calibrated), 0);
        step(1'b0, CODE_W'(MID));
        chk("R8 at threshold", int'(calibrated), 1);
        for (int i = 0; i < 200; i++) begin
            step(i[0], CODE_W'(MID));
        end
        chk("R9 stays calibrated", int'(calibrated), 1);
        chk("R9 code unchanged", int'(cur_code), MID);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule